// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a register-driven controller that talks to external PHY devices over a two-wire management bus. It builds the serial clock from the system clock. It shifts out management frames in either the short-address format (Clause 22) or the extended indirect-address format (Clause 45). It releases the data line so that a PHY can answer read requests, and it captures the sixteen bits that come back.

Software talks to it through four 32-bit words, selected by a 2-bit word index:

| Index | Byte offset | Register |
|-------|-------------|----------|
| 0 | 0x0 | configuration and status |
| 1 | 0x4 | control |
| 2 | 0x8 | data |
| 3 | 0xC | address |

Three of these words also launch transfers:

- Writing the data word sends a write frame.
- Writing the control word with its read bit set sends a read frame.
- Writing the address word while Clause 45 mode is selected sends an address frame.

Software then polls the busy flag. When busy is clear, it collects read data from the data word and checks the read-error flag.

Top module: `mdio_master`

## Requirements
- R1: After reset, all four words read as zero, the management clock `mdc` is low and the data line is released (`mdio_oe` low).
- R2: Register reads return the value one cycle after `reg_rd` is sampled. The configuration word holds these fields:
  - bit 0: busy (read-only)
  - bit 1: read error (read-only)
  - bit 6: Clause 45 select
  - bits [15:8]: half-divide value
  - bit 23: falling-edge output select

  The control word holds these fields:
  - bits [4:0]: register address (Clause 22) or device address (Clause 45)
  - bits [9:5]: PHY port address
  - bit 15: read request

  The data and address words each hold 16 bits in [15:0]. All other bits read as zero.
- R3: During a frame, `mdc` stays high for D system cycles and low for D system cycles, where D is the half-divide value and a value of 0 acts as 1. `mdc` makes exactly 64 rising edges per frame and idles low.
- R4: In Clause 22 mode, writing the data word sends a frame, MSB first, made of these fields in order:
  - 32 ones
  - start 01
  - opcode 01
  - port address (5 bits)
  - register address (5 bits)
  - turnaround 10
  - the 16 data bits
- R5: In Clause 45 mode, writing the data word sends a frame made of these fields in order:
  - 32 ones
  - start 00
  - opcode 01
  - port address
  - device address
  - turnaround 10
  - the data bits
- R6: In Clause 45 mode, writing the address word sends a frame with opcode 00 whose 16-bit payload is the address word. In Clause 22 mode the address word is stored but no frame is sent.
- R7: Writing the control word with bit 15 set sends a read frame:
  - opcode 10 in Clause 22 mode, opcode 11 in Clause 45 mode.
  - `mdio_oe` is low from the first turnaround bit to the end of the frame.
  - The 16 bits sampled on the `mdio_i` rising edges after turnaround are readable in the data word once busy clears.

  A control write with bit 15 clear sends no frame.
- R8: If `mdio_i` is high when sampled at the second turnaround bit of a read, the read-error flag is set. The flag is cleared when the next frame starts.
- R9: Busy reads as one from the cycle after a launching write until the frame ends. While busy is low, `mdio_oe` and `mdc` are low.
- R10: Every register write made while busy is set is ignored.
- R11: With the falling-edge select set, `mdio_o` changes only on falling `mdc` edges. With it clear, `mdio_o` changes only on rising `mdc` edges. In both modes, each bit is steady before the rising edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe |
| reg_idx | input | 2 | word index (byte offset divided by 4) |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | registered read data |
| mdc | output | 1 | management clock |
| mdio_o | output | 1 | management data out |
| mdio_oe | output | 1 | data line output enable |
| mdio_i | input | 1 | management data in |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Turnaround on reads.** A design that keeps driving through the turnaround would show `mdio_oe` high on the bits the PHY owns.
- **Absent PHY.** With the line left high, a design that misplaces the turnaround sample would either miss the error or flag it on a good read.
- **Stale read error.** Checking that the error clears at the next frame catches a flag that lingers.
- **Busy window.** Writes land inside the busy window; a design that does not block them would emit an extra frame or corrupt the data word.
- **Divider floor and edge select.** A half-divide of zero and both output-edge modes are run; a wrong divider floor or a wrong launch edge would show up as a bad high-phase length or as `mdio_o` moving on the sampling edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int TA_SECOND  = 47;
  localparam int DATA_FIRST = 48;
  localparam int DIV_W      = 8;

  localparam logic [1:0] IDX_CFG = 2'd0;
  localparam logic [1:0] IDX_CTL = 2'd1;
  localparam logic [1:0] IDX_DAT = 2'd2;
  localparam logic [1:0] IDX_ADR = 2'd3;

  typedef enum logic [1:0] {FR_WRITE, FR_READ, FR_ADDR} frame_kind_e;

  // assembles the whole serial frame, MSB sent first
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic        ext_mode,
    input frame_kind_e kind,
    input logic [4:0]  port,
    input logic [4:0]  dev,
    input logic [15:0] payload
  );
    logic [1:0] st;
    logic [1:0] op;
    logic [1:0] ta;
    logic [15:0] body;
    st = ext_mode ? 2'b00 : 2'b01;
    case (kind)
      FR_READ: op = ext_mode ? 2'b11 : 2'b10;
      FR_ADDR: op = 2'b00;
      default: op = 2'b01;
    endcase
    ta   = (kind == FR_READ) ? 2'b11 : 2'b10;
    body = (kind == FR_READ) ? 16'hFFFF : payload;
    return {32'hFFFF_FFFF, st, op, port, dev, ta, body};
  endfunction
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic                  rd,
  input  logic [1:0]            idx,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic                  seq_active,
  input  logic                  seq_done,
  input  logic                  seq_was_read,
  input  logic                  seq_err,
  input  logic [15:0]           seq_word,
  output logic                  busy,
  output logic                  start,
  output frame_kind_e           kind,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  neg_edge,
  output logic [DIV_W-1:0]      half_div
);
  logic        ext_q;
  logic        err_q;
  logic [4:0]  dev_q;
  logic [4:0]  port_q;
  logic        rdreq_q;
  logic [15:0] data_q;
  logic [15:0] adr_q;

  assign busy = start | seq_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q    <= 1'b0;
      err_q    <= 1'b0;
      dev_q    <= '0;
      port_q   <= '0;
      rdreq_q  <= 1'b0;
      data_q   <= '0;
      adr_q    <= '0;
      neg_edge <= 1'b0;
      half_div <= '0;
      start    <= 1'b0;
      kind     <= FR_WRITE;
      frame    <= '0;
      rdata    <= '0;
    end else begin
      start <= 1'b0;
      if (wr && !busy) begin
        case (idx)
          IDX_CFG: begin
            ext_q    <= wdata[6];
            half_div <= wdata[15:8];
            neg_edge <= wdata[23];
          end
          IDX_CTL: begin
            dev_q   <= wdata[4:0];
            port_q  <= wdata[9:5];
            rdreq_q <= wdata[15];
            if (wdata[15]) begin
              start <= 1'b1;
              kind  <= FR_READ;
              frame <= build_frame(ext_q, FR_READ, wdata[9:5], wdata[4:0], 16'h0000);
            end
          end
          IDX_DAT: begin
            data_q <= wdata[15:0];
            start  <= 1'b1;
            kind   <= FR_WRITE;
            frame  <= build_frame(ext_q, FR_WRITE, port_q, dev_q, wdata[15:0]);
          end
          default: begin
            adr_q <= wdata[15:0];
            if (ext_q) begin
              start <= 1'b1;
              kind  <= FR_ADDR;
              frame <= build_frame(ext_q, FR_ADDR, port_q, dev_q, wdata[15:0]);
            end
          end
        endcase
      end
      if (start) err_q <= 1'b0;
      if (seq_done && seq_was_read) begin
        data_q <= seq_word;
        err_q  <= seq_err;
      end
      if (rd) begin
        case (idx)
          IDX_CFG: rdata <= {8'h00, neg_edge, 7'h00, half_div, 1'b0, ext_q, 4'h0, err_q, busy};
          IDX_CTL: rdata <= {16'h0000, rdreq_q, 5'h00, port_q, dev_q};
          IDX_DAT: rdata <= {16'h0000, data_q};
          default: rdata <= {16'h0000, adr_q};
        endcase
      end
    end
  end

  // R10: a write that arrives during a frame leaves stored fields untouched
  a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr && busy && !seq_done) |=> ($stable(data_q) && $stable(adr_q) && $stable(ext_q) && $stable(half_div)));

  // R8: the error flag only rises as a read frame completes
  a_r8_err_after_read: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(seq_done && seq_was_read));
endmodule

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] half_div,
  output logic          mdc,
  output logic          rise,
  output logic          fall
);
  logic [DW-1:0] cnt;
  logic [DW-1:0] half;
  logic          last;

  assign half = (half_div == '0) ? DW'(1) : half_div;
  assign last = (cnt == half - DW'(1));
  assign rise = run && last && !mdc;
  assign fall = run && last && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (last) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + DW'(1);
    end
  end

  // R3: each phase lasts at most the programmed half period
  a_r3_phase_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < half));
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  frame_kind_e           kind,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  neg_edge,
  input  logic                  rise,
  input  logic                  fall,
  input  logic                  mdio_i,
  output logic                  active,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done,
  output logic                  was_read,
  output logic                  ta_bad,
  output logic [15:0]           rx_word
);
  localparam int CW = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] fr_q;
  logic [CW-1:0]         sampled;
  logic [5:0]            pos_next_r;
  logic [5:0]            pos_next_f;

  assign pos_next_r = 6'(FRAME_BITS - 2) - sampled[5:0];
  assign pos_next_f = 6'(FRAME_BITS - 1) - sampled[5:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      fr_q     <= '0;
      sampled  <= '0;
      active   <= 1'b0;
      mdio_o   <= 1'b0;
      mdio_oe  <= 1'b0;
      done     <= 1'b0;
      was_read <= 1'b0;
      ta_bad   <= 1'b0;
      rx_word  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        fr_q     <= frame;
        was_read <= (kind == FR_READ);
        active   <= 1'b1;
        sampled  <= '0;
        mdio_o   <= frame[FRAME_BITS-1];
        mdio_oe  <= 1'b1;
        ta_bad   <= 1'b0;
      end else if (active) begin
        if (rise) begin
          sampled <= sampled + CW'(1);
          if (was_read && sampled == CW'(TA_SECOND)) ta_bad <= mdio_i;
          if (was_read && sampled >= CW'(DATA_FIRST)) rx_word <= {rx_word[14:0], mdio_i};
          if (!neg_edge && sampled < CW'(FRAME_BITS - 1)) begin
            mdio_o  <= fr_q[pos_next_r];
            mdio_oe <= !was_read || (sampled + CW'(1) < CW'(TA_FIRST));
          end
        end
        if (fall) begin
          if (sampled == CW'(FRAME_BITS)) begin
            active  <= 1'b0;
            mdio_oe <= 1'b0;
            done    <= 1'b1;
          end else if (neg_edge) begin
            mdio_o  <= fr_q[pos_next_f];
            mdio_oe <= !was_read || (sampled < CW'(TA_FIRST));
          end
        end
      end
    end
  end

  // R7: line stays released from the second turnaround bit on
  a_r7_released_for_phy: assert property (@(posedge clk) disable iff (rst)
    (active && was_read && sampled >= CW'(TA_SECOND)) |-> !mdio_oe);

  // R11: falling-edge mode never moves the output on a rising edge
  a_r11_hold_on_rise: assert property (@(posedge clk) disable iff (rst)
    (active && neg_edge && rise) |=> $stable(mdio_o));

  // R11: rising-edge mode never moves the output on a falling edge
  a_r11_hold_on_fall: assert property (@(posedge clk) disable iff (rst)
    (active && !neg_edge && fall) |=> $stable(mdio_o));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                  busy;
  logic                  start;
  frame_kind_e           kind;
  logic [FRAME_BITS-1:0] frame;
  logic                  neg_edge;
  logic [DIV_W-1:0]      half_div;
  logic                  active;
  logic                  done;
  logic                  was_read;
  logic                  ta_bad;
  logic [15:0]           rx_word;
  logic                  rise;
  logic                  fall;

  mdio_regs u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr           (reg_wr),
    .rd           (reg_rd),
    .idx          (reg_idx),
    .wdata        (reg_wdata),
    .rdata        (reg_rdata),
    .seq_active   (active),
    .seq_done     (done),
    .seq_was_read (was_read),
    .seq_err      (ta_bad),
    .seq_word     (rx_word),
    .busy         (busy),
    .start        (start),
    .kind         (kind),
    .frame        (frame),
    .neg_edge     (neg_edge),
    .half_div     (half_div)
  );

  mdio_mdc_gen #(.DW(DIV_W)) u_mdc (
    .clk      (clk),
    .rst      (rst),
    .run      (active),
    .half_div (half_div),
    .mdc      (mdc),
    .rise     (rise),
    .fall     (fall)
  );

  mdio_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .kind     (kind),
    .frame    (frame),
    .neg_edge (neg_edge),
    .rise     (rise),
    .fall     (fall),
    .mdio_i   (mdio_i),
    .active   (active),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (done),
    .was_read (was_read),
    .ta_bad   (ta_bad),
    .rx_word  (rx_word)
  );

  // R9: when no transfer is pending the bus is quiet
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdio_oe && !mdc));
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [1:0]  idx = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  mdio_master i_mdio_master (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (wr),
    .reg_rd    (rd),
    .reg_idx   (idx),
    .reg_wdata (wdata),
    .reg_rdata (rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .mdio_i    (mdio_i)
  );

  // scoreboard queues
  logic [63:0] exp_bits[$];
  int          exp_drv[$];
  string       exp_tag[$];

  // simple PHY responder
  logic        phy_present = 1'b0;
  logic [15:0] phy_word = '0;
  int          rc = 0;
  assign mdio_i = (phy_present && rc >= 47 && rc <= 63) ?
                  ((rc == 47) ? 1'b0 : phy_word[63 - rc]) : 1'b1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor
  logic        prev_mdc = 1'b0;
  logic        prev_o = 1'b0;
  logic        prev_oe = 1'b0;
  logic [63:0] got_b = '0;
  logic [63:0] got_e = '0;
  int          hi_len = 0;
  int          last_hi = 0;
  int          chg_rise = 0;
  int          chg_fall = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_oe && mdio_oe && (mdio_o != prev_o)) begin
        if (mdc && !prev_mdc) chg_rise++;
        if (!mdc && prev_mdc) chg_fall++;
      end
      if (mdc && !prev_mdc) begin
        got_b[63 - rc] = prev_o;
        got_e[63 - rc] = prev_oe;
        rc++;
        hi_len = 0;
        if (rc == 64) begin
          rc = 0;
          if (exp_bits.size() == 0) begin
            chk(1'b0, "R10 unexpected frame", got_b, 64'h0);
          end else begin
            logic [63:0] eb;
            int          nd;
            string       tg;
            bit          ok;
            eb = exp_bits.pop_front();
            nd = exp_drv.pop_front();
            tg = exp_tag.pop_front();
            ok = 1'b1;
            for (int i = 0; i < 64; i++) begin
              if (i < nd) begin
                if (got_b[63 - i] !== eb[63 - i] || got_e[63 - i] !== 1'b1) ok = 1'b0;
              end else begin
                if (got_e[63 - i] !== 1'b0) ok = 1'b0;
              end
            end
            chk(ok, tg, got_b, eb);
          end
        end
      end
      if (mdc) hi_len++;
      if (!mdc && prev_mdc) last_hi = hi_len;
    end
    prev_mdc = mdc;
    prev_o   = mdio_o;
    prev_oe  = mdio_oe;
  end

  function automatic logic [63:0] mk(input bit ext, input int kind, input logic [4:0] port,
                                     input logic [4:0] dev, input logic [15:0] pay);
    logic [1:0] op;
    if (kind == 1) op = ext ? 2'b11 : 2'b10;
    else if (kind == 2) op = 2'b00;
    else op = 2'b01;
    return {32'hFFFF_FFFF, (ext ? 2'b00 : 2'b01), op, port, dev, 2'b10, pay};
  endfunction

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; idx = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; idx = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int n = 0; n < 4000; n++) begin
      bus_rd(2'd0, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  task automatic expect_frame(input logic [63:0] b, input int nd, input string tg);
    exp_bits.push_back(b);
    exp_drv.push_back(nd);
    exp_tag.push_back(tg);
  endtask

  bit timed_out = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    timed_out = 1'b1;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle pins", {62'b0, mdc, mdio_oe}, 64'h0);
    for (int a = 0; a < 4; a++) begin
      bus_rd(a[1:0], v);
      chk(v == 32'h0, "R1 reset word", {32'h0, v}, 64'h0);
    end

    // R2 configuration and control readback (Clause 22, half divide 2, rising-edge launch)
    bus_wr(2'd0, 32'h0000_0200);
    bus_rd(2'd0, v);
    chk(v == 32'h0000_0200, "R2 cfg readback", {32'h0, v}, 64'h200);
    bus_wr(2'd1, 32'h0000_0000 | (5'd3 << 5) | 5'd9);
    bus_rd(2'd1, v);
    chk(v == ((32'd3 << 5) | 32'd9), "R2 ctl readback", {32'h0, v}, (64'd3 << 5) | 64'd9);

    // R7 control write without read bit launches nothing
    repeat (3) @(negedge clk);
    bus_rd(2'd0, v);
    chk(v[0] == 1'b0, "R7 no frame without read bit", {32'h0, v}, 64'h0);

    // R6 Clause 22 address write stores only
    bus_wr(2'd3, 32'h0000_BEEF);
    repeat (3) @(negedge clk);
    bus_rd(2'd0, v);
    chk(v[0] == 1'b0, "R6 no address frame in clause 22", {32'h0, v}, 64'h0);
    bus_rd(2'd3, v);
    chk(v == 32'h0000_BEEF, "R2 address readback", {32'h0, v}, 64'hBEEF);

    // R4 Clause 22 write frame, R9 busy, R10 ignored writes
    chk_reset_edges();
    expect_frame(mk(1'b0, 0, 5'd3, 5'd9, 16'hA55A), 64, "R4 clause 22 write frame");
    bus_wr(2'd2, 32'h0000_A55A);
    bus_rd(2'd0, v);
    chk(v[0] == 1'b1, "R9 busy after launch", {32'h0, v}, 64'h1);
    bus_wr(2'd2, 32'h0000_1234);
    bus_wr(2'd1, 32'h0000_8000);
    bus_wr(2'd0, 32'h0080_0540);
    wait_idle();
    bus_rd(2'd2, v);
    chk(v == 32'h0000_A55A, "R10 data kept during busy", {32'h0, v}, 64'hA55A);
    bus_rd(2'd1, v);
    chk(v == ((32'd3 << 5) | 32'd9), "R10 ctl kept during busy", {32'h0, v}, (64'd3 << 5) | 64'd9);
    bus_rd(2'd0, v);
    chk(v == 32'h0000_0200, "R10 cfg kept during busy", {32'h0, v}, 64'h200);
    chk(last_hi == 2, "R3 high phase length", 64'(last_hi), 64'd2);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R9 idle after frame", {62'b0, mdc, mdio_oe}, 64'h0);

    // R7 Clause 22 read with PHY present
    phy_present = 1'b1;
    phy_word = 16'hC0DE;
    expect_frame(mk(1'b0, 1, 5'd4, 5'd2, 16'h0), 46, "R7 clause 22 read header");
    bus_wr(2'd1, 32'h0000_8000 | (32'd4 << 5) | 32'd2);
    wait_idle();
    bus_rd(2'd2, v);
    chk(v == 32'h0000_C0DE, "R7 read data", {32'h0, v}, 64'hC0DE);
    bus_rd(2'd0, v);
    chk(v[1] == 1'b0, "R8 no error with PHY", {32'h0, v}, 64'h0);
    chk(chg_fall == 0 && chg_rise > 0, "R11 rising-edge launch",
        {32'(chg_rise), 32'(chg_fall)}, 64'h1_0000_0000);

    // R8 absent PHY
    phy_present = 1'b0;
    expect_frame(mk(1'b0, 1, 5'd4, 5'd2, 16'h0), 46, "R8 read header absent PHY");
    bus_wr(2'd1, 32'h0000_8000 | (32'd4 << 5) | 32'd2);
    wait_idle();
    bus_rd(2'd0, v);
    chk(v[1] == 1'b1, "R8 error flag set", {32'h0, v}, 64'h2);
    bus_rd(2'd2, v);
    chk(v == 32'h0000_FFFF, "R8 data with no PHY", {32'h0, v}, 64'hFFFF);
    expect_frame(mk(1'b0, 0, 5'd4, 5'd2, 16'h0F0F), 64, "R4 write after error");
    bus_wr(2'd2, 32'h0000_0F0F);
    repeat (3) @(negedge clk);
    bus_rd(2'd0, v);
    chk(v[1] == 1'b0 && v[0] == 1'b1, "R8 error cleared at next frame", {32'h0, v}, 64'h1);
    wait_idle();

    // Clause 45, falling-edge launch, half divide 0
    bus_wr(2'd0, 32'h0080_0040);
    bus_rd(2'd0, v);
    chk(v == 32'h0080_0040, "R2 cfg clause 45 readback", {32'h0, v}, 64'h0080_0040);
    bus_wr(2'd1, (32'd7 << 5) | 32'd1);
    chk_reset_edges();
    expect_frame(mk(1'b1, 2, 5'd7, 5'd1, 16'h4321), 64, "R6 clause 45 address frame");
    bus_wr(2'd3, 32'h0000_4321);
    wait_idle();
    chk(last_hi == 1, "R3 zero divide acts as one", 64'(last_hi), 64'd1);
    expect_frame(mk(1'b1, 0, 5'd7, 5'd1, 16'h9876), 64, "R5 clause 45 write frame");
    bus_wr(2'd2, 32'h0000_9876);
    wait_idle();
    phy_present = 1'b1;
    phy_word = 16'h5AA5;
    expect_frame(mk(1'b1, 1, 5'd7, 5'd1, 16'h0), 46, "R7 clause 45 read header");
    bus_wr(2'd1, 32'h0000_8000 | (32'd7 << 5) | 32'd1);
    wait_idle();
    bus_rd(2'd2, v);
    chk(v == 32'h0000_5AA5, "R7 clause 45 read data", {32'h0, v}, 64'h5AA5);
    chk(chg_rise == 0 && chg_fall > 0, "R11 falling-edge launch",
        {32'(chg_rise), 32'(chg_fall)}, 64'h1);

    repeat (20) @(negedge clk);
    chk(exp_bits.size() == 0, "R10 all expected frames seen", 64'(exp_bits.size()), 64'h0);

    if (!timed_out) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk_reset_edges();
    chg_rise = 0;
    chg_fall = 0;
  endtask
endmodule